// File: doc/BRIEF.md
# Completion Interrupt Coalescer

This block sits beside one work queue and decides when software should be interrupted about finished work. Every finished job that asked for a completion interrupt adds one to a pending count. A hold-off timer runs while that count is nonzero. The interrupt line rises when the count reaches a programmed number of jobs, or when the timer reaches a programmed time. The time is given in coarse ticks of 2^TICK_LOG2 clocks, which is 1024 clocks by default.

Software services the queue by writing an acknowledge value. The block subtracts that value from the pending count and restarts the timer. The condition is then evaluated again from the new count, so a job that finishes while software is acknowledging still raises the line. An enable bit gates only the output. It is changed through separate set and clear registers, in which only bit 0 acts, and counting and timing go on while the output is masked.

Top module: `done_coalesce`

## Requirements
- R1: A cycle with `cmpl_vld`=1 and `cmpl_irq_req`=1 increments the pending count by one. A completion with `cmpl_irq_req`=0 leaves the count unchanged.
- R2: A write to address 1 (acknowledge) subtracts `reg_wdata[CNT_W-1:0]` from the count. Reading address 0 or 1 returns the count. An acknowledge and a counted completion in the same cycle apply their net change.
- R3: While the count is zero, the timer is held at zero and `done_irq` is low.
- R4: The count condition holds when count >= the threshold at address 2. A threshold of 0 acts as 1.
- R5: The time condition holds when the timer >= (field at address 3) * 2^TICK_LOG2. The timer counts one per clock while the count is nonzero. A field value of 0 disables the time condition.
- R6: A write to address 1, or a direct write of the count at address 0, restarts the timer from zero. The conditions are then checked again against the updated count in the next cycle.
- R7: Writing 1 in bit 0 at address 4 sets the enable, and writing 1 in bit 0 at address 5 clears it. A 0 in bit 0 has no effect. While the enable is clear, `done_irq` is low but counting and timing continue. Addresses 4 and 5 read the enable in bit 0.
- R8: The timer saturates at its maximum value and does not wrap.
- R9: `done_irq` is a level that stays high in every cycle in which the enable is set and the count condition or the time condition holds.
- R10: After reset the count, the timer, both thresholds and the enable are zero. A direct write at address 0 loads the count. Addresses 2 and 3 read back their thresholds at bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmpl_vld | input | 1 | A job finished this cycle |
| cmpl_irq_req | input | 1 | The finished job asked for an interrupt |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| done_irq | output | 1 | Coalesced completion interrupt level |

## Verification
The bench builds the block with TICK_LOG2=2 and a 4-bit time field. A time threshold is then at most 60 clocks, and the 6-bit timer reaches its ceiling at 63. This short range lets the bench find the exact cycle in which the time condition fires, see an acknowledge restart the wait, and hold the count long enough past the ceiling that a timer which wraps would drop the line. The count keeps its full 20-bit width, so acknowledge arithmetic and count thresholds behave as in the default build.

// File: rtl/done_coalesce_pkg.sv
package done_coalesce_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_COUNT  = 3'd0,
    RA_ACK    = 3'd1,
    RA_NUMTHR = 3'd2,
    RA_TIMTHR = 3'd3,
    RA_ENSET  = 3'd4,
    RA_ENCLR  = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/done_coalesce_cfg.sv
module done_coalesce_cfg #(
  parameter int CNT_W = 20,
  parameter int TW_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_num,
  input  logic             wr_tim,
  input  logic             wr_set,
  input  logic             wr_clr,
  input  logic [31:0]      wdata,
  output logic [CNT_W-1:0] num_thr,
  output logic [TW_W-1:0]  tim_thr,
  output logic             irq_en
);
  logic [CNT_W-1:0] num_d;
  logic [TW_W-1:0]  tim_d;
  logic             en_d;

  always_comb begin
    num_d = num_thr;
    tim_d = tim_thr;
    en_d  = irq_en;
    if (wr_num) num_d = wdata[CNT_W-1:0];
    if (wr_tim) tim_d = wdata[TW_W-1:0];
    if (wr_set && wdata[0]) en_d = 1'b1;
    if (wr_clr && wdata[0]) en_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_thr <= '0;
      tim_thr <= '0;
      irq_en  <= 1'b0;
    end else begin
      num_thr <= num_d;
      tim_thr <= tim_d;
      irq_en  <= en_d;
    end
  end

  assert_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_set && wdata[0] && !wr_clr) |=> irq_en);
  assert_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && wdata[0] && !wr_set) |=> !irq_en);
  assert_zero_noeffect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_set || wr_clr) && !wdata[0]) |=> $stable(irq_en));
endmodule

// File: rtl/done_coalesce_count.sv
module done_coalesce_count #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             load,
  input  logic             ack,
  input  logic [CNT_W-1:0] wval,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (load)     base = wval;
    else if (ack) base = cnt - wval;
    else          base = cnt;
    cnt_d = base + {{(CNT_W-1){1'b0}}, inc};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  assert_inc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && !ack) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !load && !ack) |=> $stable(cnt));
endmodule

// File: rtl/done_coalesce_timer.sv
module done_coalesce_timer #(
  parameter int TMR_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_zero,
  output logic [TMR_W-1:0] tmr
);
  localparam logic [TMR_W-1:0] TMR_MAX = {TMR_W{1'b1}};
  logic [TMR_W-1:0] tmr_d;

  always_comb begin
    if (hold_zero)           tmr_d = '0;
    else if (tmr == TMR_MAX) tmr_d = TMR_MAX;
    else                     tmr_d = tmr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr <= '0;
    else        tmr <= tmr_d;
  end

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_zero |=> (tmr == '0));
  assert_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_zero && tmr == TMR_MAX) |=> (tmr == TMR_MAX));
endmodule

// File: rtl/done_coalesce_eval.sv
module done_coalesce_eval #(
  parameter int CNT_W     = 20,
  parameter int TW_W      = 16,
  parameter int TICK_LOG2 = 10,
  parameter int TMR_W     = TW_W + TICK_LOG2
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [TMR_W-1:0] tmr,
  input  logic [CNT_W-1:0] num_thr,
  input  logic [TW_W-1:0]  tim_thr,
  input  logic             irq_en,
  output logic             irq
);
  logic [TMR_W-1:0] tim_limit;
  logic [CNT_W-1:0] num_eff;
  logic             time_hit;
  logic             num_hit;

  generate
    if (TICK_LOG2 == 0) begin : g_unscaled
      assign tim_limit = TMR_W'(tim_thr);
    end else begin : g_scaled
      assign tim_limit = {tim_thr, {TICK_LOG2{1'b0}}};
    end
  endgenerate

  always_comb begin
    num_eff  = (num_thr == '0) ? CNT_W'(1) : num_thr;
    time_hit = (tim_thr != '0) && (tmr >= tim_limit);
    num_hit  = (cnt >= num_eff);
    irq      = irq_en && (cnt != '0) && (time_hit || num_hit);
  end
endmodule

// File: rtl/done_coalesce.sv
module done_coalesce
  import done_coalesce_pkg::*;
#(
  parameter int CNT_W     = 20,
  parameter int TW_W      = 16,
  parameter int TICK_LOG2 = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmpl_vld,
  input  logic        cmpl_irq_req,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        done_irq
);
  localparam int TMR_W = TW_W + TICK_LOG2;

  logic             inc;
  logic             wr_count, wr_ack, wr_num, wr_tim, wr_set, wr_clr;
  logic [CNT_W-1:0] cnt;
  logic [TMR_W-1:0] tmr;
  logic [CNT_W-1:0] num_thr;
  logic [TW_W-1:0]  tim_thr;
  logic             irq_en;
  logic             restart;

  always_comb begin
    inc      = cmpl_vld && cmpl_irq_req;
    wr_count = reg_wr && (reg_addr == RA_COUNT);
    wr_ack   = reg_wr && (reg_addr == RA_ACK);
    wr_num   = reg_wr && (reg_addr == RA_NUMTHR);
    wr_tim   = reg_wr && (reg_addr == RA_TIMTHR);
    wr_set   = reg_wr && (reg_addr == RA_ENSET);
    wr_clr   = reg_wr && (reg_addr == RA_ENCLR);
    restart  = wr_count || wr_ack;
  end

  done_coalesce_cfg #(.CNT_W(CNT_W), .TW_W(TW_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_num(wr_num), .wr_tim(wr_tim), .wr_set(wr_set), .wr_clr(wr_clr),
    .wdata(reg_wdata),
    .num_thr(num_thr), .tim_thr(tim_thr), .irq_en(irq_en)
  );

  done_coalesce_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n),
    .inc(inc), .load(wr_count), .ack(wr_ack),
    .wval(reg_wdata[CNT_W-1:0]),
    .cnt(cnt)
  );

  done_coalesce_timer #(.TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .hold_zero((cnt == '0) || restart),
    .tmr(tmr)
  );

  done_coalesce_eval #(.CNT_W(CNT_W), .TW_W(TW_W), .TICK_LOG2(TICK_LOG2),
                       .TMR_W(TMR_W)) u_eval (
    .cnt(cnt), .tmr(tmr), .num_thr(num_thr), .tim_thr(tim_thr),
    .irq_en(irq_en), .irq(done_irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_COUNT, RA_ACK:  reg_rdata[CNT_W-1:0] = cnt;
      RA_NUMTHR:         reg_rdata[CNT_W-1:0] = num_thr;
      RA_TIMTHR:         reg_rdata[TW_W-1:0]  = tim_thr;
      RA_ENSET, RA_ENCLR: reg_rdata[0]        = irq_en;
      default:           reg_rdata = '0;
    endcase
  end

  assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> (tmr == '0 && !done_irq));
  assert_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !done_irq);
  assert_numhit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && cnt != '0 && cnt >= num_thr) |-> done_irq);
  assert_ack_net_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && inc) |=> (cnt == CNT_W'($past(cnt) - $past(reg_wdata[CNT_W-1:0]) + 1'b1)));
endmodule

// File: tb/done_coalesce_tb.sv
module done_coalesce_tb;
  localparam int CNT_W = 20;
  localparam int TW_W = 4;
  localparam int TICK_LOG2 = 2;
  localparam longint CMASK = (64'd1 << CNT_W) - 1;
  localparam longint TMAX = (64'd1 << (TW_W + TICK_LOG2)) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmpl_vld = 1'b0, cmpl_irq_req = 1'b0, reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        done_irq;

  int total = 0, bad = 0;
  bit fin = 1'b0;
  logic [2:0] rsel = 3'd0;

  longint m_cnt, m_tmr, m_num, m_tw;
  bit     m_en;

  always #10 clk = ~clk;

  done_coalesce #(.CNT_W(CNT_W), .TW_W(TW_W), .TICK_LOG2(TICK_LOG2)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmpl_vld(cmpl_vld), .cmpl_irq_req(cmpl_irq_req),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .done_irq(done_irq)
  );

  function automatic bit exp_irq();
    bit th, nh;
    th = (m_tw != 0) && (m_tmr >= (m_tw << TICK_LOG2));
    nh = m_cnt >= ((m_num == 0) ? 1 : m_num);
    return m_en && (m_cnt != 0) && (th || nh);
  endfunction

  function automatic longint exp_rd(input logic [2:0] a);
    case (a)
      3'd0, 3'd1: return m_cnt;
      3'd2: return m_num;
      3'd3: return m_tw;
      3'd4, 3'd5: return longint'(m_en);
      default: return 0;
    endcase
  endfunction

  // Behavioural reference, advanced on every clock edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_tmr = 0; m_num = 0; m_tw = 0; m_en = 0;
    end else begin
      longint ninc, wv, ncnt, ntmr;
      bit rst_t;
      ninc = (cmpl_vld && cmpl_irq_req) ? 1 : 0;
      wv = longint'(reg_wdata) & CMASK;
      rst_t = reg_wr && (reg_addr == 3'd0 || reg_addr == 3'd1);
      if (reg_wr && reg_addr == 3'd0)      ncnt = (wv + ninc) & CMASK;
      else if (reg_wr && reg_addr == 3'd1) ncnt = (m_cnt - wv + ninc) & CMASK;
      else                                 ncnt = (m_cnt + ninc) & CMASK;
      if (m_cnt == 0 || rst_t) ntmr = 0;
      else ntmr = (m_tmr >= TMAX) ? TMAX : m_tmr + 1;
      m_cnt = ncnt; m_tmr = ntmr;
      if (reg_wr && reg_addr == 3'd2) m_num = wv;
      if (reg_wr && reg_addr == 3'd3) m_tw = longint'(reg_wdata[TW_W-1:0]);
      if (reg_wr && reg_addr == 3'd4 && reg_wdata[0]) m_en = 1'b1;
      if (reg_wr && reg_addr == 3'd5 && reg_wdata[0]) m_en = 1'b0;
    end
  end

  // Per-cycle comparison against the reference, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !fin) begin
      total++;
      if (done_irq !== exp_irq()) begin
        bad++;
        $display("FAIL model R9: done_irq actual=%0b expected=%0b", done_irq, exp_irq());
      end
      total++;
      if (longint'(reg_rdata) != exp_rd(reg_addr)) begin
        bad++;
        $display("FAIL model R10: rdata@%0d actual=%0h expected=%0h", reg_addr, reg_rdata, exp_rd(reg_addr));
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic op(input bit cv, input bit cf, input bit w, input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    cmpl_vld = cv; cmpl_irq_req = cf; reg_wr = w;
    reg_addr = w ? a : rsel; reg_wdata = d;
  endtask

  task automatic idle();
    op(1'b0, 1'b0, 1'b0, 3'd0, 32'd0);
  endtask

  task automatic settle();
    idle();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    op(1'b0, 1'b0, 1'b1, a, d);
  endtask

  task automatic finish_run();
    fin = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(reg_rdata == 0, "R10 reset count", reg_rdata, 0);
    chk(done_irq == 0, "R10 reset irq", done_irq, 0);
    rsel = 3'd4; settle();
    chk(reg_rdata == 0, "R10 reset enable", reg_rdata, 0);
    rsel = 3'd0;

    // Count threshold
    wr(3'd4, 32'd1); wr(3'd2, 32'd3);
    op(1, 1, 0, 0, 0); op(1, 1, 0, 0, 0); op(1, 0, 0, 0, 0); settle();
    chk(reg_rdata == 2, "R1 flagged count", reg_rdata, 2);
    chk(done_irq == 0, "R4 below threshold", done_irq, 0);
    op(1, 1, 0, 0, 0); settle();
    chk(done_irq == 1, "R4 at threshold", done_irq, 1);
    for (int i = 0; i < 5; i++) begin
      idle(); @(negedge clk);
      chk(done_irq == 1, "R9 level held", done_irq, 1);
    end

    // Acknowledge
    wr(3'd1, 32'd2); settle();
    chk(reg_rdata == 1, "R2 ack subtract", reg_rdata, 1);
    chk(done_irq == 0, "R6 reevaluated low", done_irq, 0);
    rsel = 3'd1; settle();
    chk(reg_rdata == 1, "R2 ack readback", reg_rdata, 1);
    rsel = 3'd0;
    op(1, 1, 1, 3'd1, 32'd1); settle();
    chk(reg_rdata == 1, "R2 net change", reg_rdata, 1);
    op(1, 1, 1, 3'd1, 32'd0); settle();
    chk(reg_rdata == 2, "R2 ack zero with inc", reg_rdata, 2);
    chk(done_irq == 0, "R4 count 2 of 3", done_irq, 0);
    wr(3'd2, 32'd0); settle();
    chk(done_irq == 1, "R4 zero threshold acts as one", done_irq, 1);

    // Enable set/clear
    wr(3'd5, 32'd1); settle();
    chk(done_irq == 0, "R7 clear masks", done_irq, 0);
    wr(3'd4, 32'd2); settle();
    chk(done_irq == 0, "R7 zero bit0 no effect", done_irq, 0);
    op(1, 1, 0, 0, 0); settle();
    chk(reg_rdata == 3, "R7 counting while masked", reg_rdata, 3);
    wr(3'd4, 32'd1); wr(3'd5, 32'd0); settle();
    chk(done_irq == 1, "R7 set unmasks, clear with 0 ignored", done_irq, 1);

    // Direct load to zero
    wr(3'd0, 32'd0); settle();
    chk(reg_rdata == 0, "R10 direct load", reg_rdata, 0);
    chk(done_irq == 0, "R3 zero count no irq", done_irq, 0);
    repeat (5) idle();
    @(negedge clk);
    chk(done_irq == 0, "R3 stays low", done_irq, 0);

    // Time threshold: 2 ticks of 4 clocks = 8
    wr(3'd2, 32'd100); wr(3'd3, 32'd2);
    op(1, 1, 0, 0, 0); settle();
    for (int i = 0; i < 11; i++) begin
      chk(done_irq == (i >= 8), "R5 time threshold", done_irq, (i >= 8));
      idle(); @(negedge clk);
    end
    wr(3'd1, 32'd0); settle();
    for (int i = 0; i < 11; i++) begin
      chk(done_irq == (i >= 8), "R6 ack restarts timer", done_irq, (i >= 8));
      idle(); @(negedge clk);
    end
    wr(3'd3, 32'd0); wr(3'd1, 32'd0);
    repeat (20) idle();
    @(negedge clk);
    chk(done_irq == 0, "R5 zero time disables", done_irq, 0);

    // Saturation: threshold 60, timer ceiling 63
    wr(3'd3, 32'd15); wr(3'd1, 32'd0); settle();
    for (int i = 0; i < 120; i++) begin
      idle(); @(negedge clk);
    end
    chk(done_irq == 1, "R8 timer saturates", done_irq, 1);

    rsel = 3'd2; settle();
    chk(reg_rdata == 100, "R10 count threshold readback", reg_rdata, 100);
    rsel = 3'd3; settle();
    chk(reg_rdata == 15, "R10 time threshold readback", reg_rdata, 15);
    rsel = 3'd0; settle();
    finish_run();
  end
endmodule